// File: doc/BRIEF.md
# Remote DMA Channel Controller

This block moves data between a local packet memory and a host data port, one host access at a time. Software programs a 16-bit start address and a 16-bit byte count, each as two 8-bit halves, and then writes a 3-bit command. The command selects a host read (memory to host) or a host write (host to memory), or aborts the current transfer. Each strobe on the host data port moves one byte or one 16-bit word. It also advances the current address and lowers the remaining count by the same step. When the count reaches zero the transfer stops and a completion flag is raised in the interrupt status register.

The local memory is seen as 16-bit words with two byte lanes and an asynchronous read. The even address occupies lane 0 (bits 7:0) and the odd address occupies lane 1 (bits 15:8). A configuration register selects byte or word transfers. It also selects whether the lower-addressed byte of a word sits in the low or the high half of the host word. Software can read back the current address, the remaining count, the last accepted command, the configuration and the status.

Top module: `rdma_ctrl`

## Requirements
- R1: After reset the current address, remaining count, command readback, configuration and status all read 0, no transfer is running, `host_rdata` is 0 and `mem_we` is 0.
- R2: Register offsets: 1 = start address bits 7:0, 2 = start address bits 15:8, 3 = count bits 7:0, 4 = count bits 15:8. A command of 001 (host read) or 010 (host write) at offset 0 loads the current address from the start address and the remaining count from the count.
- R3: Each accepted host access advances the current address by 1 in byte mode or by 2 in word mode. It lowers the count by the same step. A count smaller than the step goes to 0, so an odd count in word mode needs ceil(count/2) accesses.
- R4: When the count reaches 0 the transfer stops and status bit 6 (offset 6) is set. A read or write command issued with a count of 0 sets bit 6 at once and moves no data.
- R5: Writing a byte with bit 6 set to offset 6 clears the completion flag. Writing 0 there leaves the flag unchanged. A completion in the same cycle as a clear leaves the flag set.
- R6: A command with bit 2 set (1xx) aborts the transfer. The current address keeps the value it had reached and the completion flag is not set. Later strobes move nothing.
- R7: Command values 000 and 011 are ignored: the transfer, the address, the count and the command readback do not change.
- R8: Configuration (offset 5): bit 0 = 1 selects word mode and bit 1 = 1 swaps the byte order. A byte read returns the addressed byte in `host_rdata[7:0]` with bits 15:8 at 0. A word read with bit 1 = 0 places the even-address byte in bits 7:0. With bit 1 = 1 it places that byte in bits 15:8. `host_rdata` updates on the clock edge that accepts the strobe.
- R9: An accepted host write drives `mem_we` = 1 in the same cycle. Word mode gives `mem_be` = 11, with `mem_wdata` equal to `host_wdata` when not swapped and byte-swapped when swapped. Byte mode gives `mem_be` = 01 at an even address or 10 at an odd address, with `host_wdata[7:0]` copied to both lanes. `mem_addr` is the current address without bit 0.
- R10: `reg_rdata` shows, one cycle after `reg_addr` is presented, the register at that offset. Offset 0 gives the last accepted command in bits 2:0. Offsets 1 and 2 give the current address low and high. Offsets 3 and 4 give the remaining count low and high. Offset 5 gives the configuration. Offset 6 gives the status.
- R11: A strobe while no transfer runs, a strobe of the direction the command did not select, or a strobe in the cycle of a command write moves no data and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| host_rd_stb | input | 1 | Host read access strobe |
| host_wr_stb | input | 1 | Host write access strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Data returned by the last accepted host read |
| mem_addr | output | 15 | Local memory word address |
| mem_rdata | input | 16 | Local memory read data (asynchronous, lane 0 = even byte) |
| mem_we | output | 1 | Local memory write enable |
| mem_be | output | 2 | Local memory byte-lane enables |
| mem_wdata | output | 16 | Local memory write data |

## Verification
The assertions assume that host strobes are single-cycle pulses. They also assume that `mem_rdata` is a pure function of `mem_addr` within the cycle and that word transfers start at even addresses. The stimulus raises only one strobe at a time and holds each for exactly one clock. It programs only even start addresses for word transfers, and it models the memory as a fixed function of the address. The property for ignored commands applies only to cycles without a strobe, and the bench never issues a 000 or 011 command together with a strobe.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [3:0] OFF_CMD   = 4'd0;
  localparam logic [3:0] OFF_ALO   = 4'd1;
  localparam logic [3:0] OFF_AHI   = 4'd2;
  localparam logic [3:0] OFF_CLO   = 4'd3;
  localparam logic [3:0] OFF_CHI   = 4'd4;
  localparam logic [3:0] OFF_CFG   = 4'd5;
  localparam logic [3:0] OFF_STAT  = 4'd6;
  localparam int         DONE_BIT  = 6;

  typedef enum logic [2:0] {
    OP_NONE = 3'b000,
    OP_HRD  = 3'b001,
    OP_HWR  = 3'b010,
    OP_SEND = 3'b011
  } op_e;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  xfer_len,
  output logic [1:0]        cfg,
  output logic [2:0]        cmd_q,
  output logic              go,
  output logic              go_write,
  output logic              abort,
  output logic              done_clr
);
  import rdma_pkg::*;

  logic cmd_hit;
  logic [ADDR_W-1:0] start_q;
  logic [CNT_W-1:0]  len_q;
  logic [1:0]        cfg_q;

  always_comb begin
    cmd_hit  = reg_wr && (reg_addr == OFF_CMD);
    abort    = cmd_hit && reg_wdata[2];
    go       = cmd_hit && !reg_wdata[2] &&
               ((reg_wdata[2:0] == OP_HRD) || (reg_wdata[2:0] == OP_HWR));
    go_write = reg_wdata[1];
    done_clr = reg_wr && (reg_addr == OFF_STAT) && reg_wdata[DONE_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      len_q   <= '0;
      cfg_q   <= '0;
      cmd_q   <= '0;
    end else begin
      if (go || abort) cmd_q <= reg_wdata[2:0];
      if (reg_wr) begin
        case (reg_addr)
          OFF_ALO: start_q[7:0]        <= reg_wdata;
          OFF_AHI: start_q[ADDR_W-1:8] <= reg_wdata[ADDR_W-9:0];
          OFF_CLO: len_q[7:0]          <= reg_wdata;
          OFF_CHI: len_q[CNT_W-1:8]    <= reg_wdata[CNT_W-9:0];
          OFF_CFG: cfg_q               <= reg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  assign start_addr = start_q;
  assign xfer_len   = len_q;
  assign cfg        = cfg_q;
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_write,
  input  logic              abort,
  input  logic              done_clr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic              word_mode,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              active,
  output logic              is_write,
  output logic              done,
  output logic              rd_fire,
  output logic              wr_fire
);
  logic [CNT_W-1:0] step;
  logic             last;
  logic             quiet;

  always_comb begin
    step    = word_mode ? CNT_W'(2) : CNT_W'(1);
    last    = (cur_cnt <= step);
    quiet   = !go && !abort;
    rd_fire = active && !is_write && rd_stb && quiet;
    wr_fire = active &&  is_write && wr_stb && quiet;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      active   <= 1'b0;
      is_write <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (done_clr) done <= 1'b0;
      if (go) begin
        cur_addr <= start_addr;
        cur_cnt  <= xfer_len;
        is_write <= go_write;
        active   <= (xfer_len != '0);
        if (xfer_len == '0) done <= 1'b1;
      end else if (abort) begin
        active <= 1'b0;
      end else if (rd_fire || wr_fire) begin
        cur_addr <= cur_addr + ADDR_W'(step);
        cur_cnt  <= last ? '0 : cur_cnt - step;
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rdma_lanes.sv
module rdma_lanes (
  input  logic        word_mode,
  input  logic        swap,
  input  logic        odd,
  input  logic [15:0] mem_rdata,
  input  logic [15:0] host_wdata,
  output logic [15:0] rd_word,
  output logic [15:0] wr_word,
  output logic [1:0]  wr_be
);
  always_comb begin
    if (!word_mode) begin
      rd_word = {8'h00, odd ? mem_rdata[15:8] : mem_rdata[7:0]};
      wr_word = {host_wdata[7:0], host_wdata[7:0]};
      wr_be   = odd ? 2'b10 : 2'b01;
    end else if (swap) begin
      rd_word = {mem_rdata[7:0], mem_rdata[15:8]};
      wr_word = {host_wdata[7:0], host_wdata[15:8]};
      wr_be   = 2'b11;
    end else begin
      rd_word = mem_rdata;
      wr_word = host_wdata;
      wr_be   = 2'b11;
    end
  end
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              host_rd_stb,
  input  logic              host_wr_stb,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic [ADDR_W-2:0] mem_addr,
  input  logic [15:0]       mem_rdata,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata
);
  import rdma_pkg::*;

  logic [ADDR_W-1:0] start_addr, cur_addr;
  logic [CNT_W-1:0]  xfer_len, cur_cnt;
  logic [1:0]        cfg;
  logic [2:0]        cmd_q;
  logic go, go_write, abort, done_clr;
  logic active, is_write, done, rd_fire, wr_fire;
  logic [15:0] rd_word, wr_word;
  logic [1:0]  wr_be;

  rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .start_addr(start_addr), .xfer_len(xfer_len),
    .cfg(cfg), .cmd_q(cmd_q), .go(go), .go_write(go_write),
    .abort(abort), .done_clr(done_clr)
  );

  rdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .go(go), .go_write(go_write), .abort(abort),
    .done_clr(done_clr), .start_addr(start_addr), .xfer_len(xfer_len),
    .word_mode(cfg[0]), .rd_stb(host_rd_stb), .wr_stb(host_wr_stb),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .active(active),
    .is_write(is_write), .done(done), .rd_fire(rd_fire), .wr_fire(wr_fire)
  );

  rdma_lanes u_lanes (
    .word_mode(cfg[0]), .swap(cfg[1]), .odd(cur_addr[0]),
    .mem_rdata(mem_rdata), .host_wdata(host_wdata),
    .rd_word(rd_word), .wr_word(wr_word), .wr_be(wr_be)
  );

  assign mem_addr  = cur_addr[ADDR_W-1:1];
  assign mem_we    = wr_fire;
  assign mem_be    = wr_fire ? wr_be : 2'b00;
  assign mem_wdata = wr_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      reg_rdata  <= '0;
    end else begin
      if (rd_fire) host_rdata <= rd_word;
      case (reg_addr)
        OFF_CMD:  reg_rdata <= {5'b0, cmd_q};
        OFF_ALO:  reg_rdata <= cur_addr[7:0];
        OFF_AHI:  reg_rdata <= 8'(cur_addr >> 8);
        OFF_CLO:  reg_rdata <= cur_cnt[7:0];
        OFF_CHI:  reg_rdata <= 8'(cur_cnt >> 8);
        OFF_CFG:  reg_rdata <= {6'b0, cfg};
        OFF_STAT: reg_rdata <= 8'(done) << DONE_BIT;
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rdma_ctrl_chk.sv
module rdma_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              host_rd_stb,
  input logic              host_wr_stb,
  input logic              mem_we,
  input logic              go,
  input logic              abort,
  input logic              active,
  input logic              is_write,
  input logic              done,
  input logic              fire,
  input logic              word_mode,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  cur_cnt
);
  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> cur_addr == $past(start_addr));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> cur_addr == $past(cur_addr) + ($past(word_mode) ? ADDR_W'(2) : ADDR_W'(1)));

  // R4
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && (word_mode ? (cur_cnt <= CNT_W'(2)) : (cur_cnt <= CNT_W'(1)))) |=> (done && !active));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd6 && reg_wdata[6] && !active) |=> !done);

  // R6
  abort_hold_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!active && $stable(cur_addr)));

  // R7
  noop_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd0 && (reg_wdata[2:0] == 3'b000 || reg_wdata[2:0] == 3'b011)
     && !host_rd_stb && !host_wr_stb) |=> ($stable(cur_addr) && $stable(active) && $stable(cur_cnt)));

  // R9
  we_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (active && is_write && host_wr_stb));
endmodule

bind rdma_ctrl rdma_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .host_rd_stb(host_rd_stb), .host_wr_stb(host_wr_stb),
  .mem_we(mem_we), .go(go), .abort(abort), .active(active),
  .is_write(is_write), .done(done), .fire(rd_fire || wr_fire),
  .word_mode(cfg[0]), .start_addr(start_addr), .cur_addr(cur_addr),
  .cur_cnt(cur_cnt)
);

// File: tb/tb_rdma_ctrl.sv
module tb_rdma_ctrl;
  logic clk = 0, rst = 1;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic host_rd_stb = 0, host_wr_stb = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic [14:0] mem_addr;
  logic [15:0] mem_rdata, mem_wdata;
  logic mem_we;
  logic [1:0] mem_be;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] fb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = {fb({mem_addr, 1'b1}), fb({mem_addr, 1'b0})};

  rdma_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic prog(input logic [15:0] s, input logic [15:0] n, input logic [1:0] c);
    wr(5, {6'b0, c}); wr(1, s[7:0]); wr(2, s[15:8]); wr(3, n[7:0]); wr(4, n[15:8]);
  endtask

  task automatic rstb(output logic [15:0] d);
    @(negedge clk); host_rd_stb = 1;
    @(negedge clk); host_rd_stb = 0; d = host_rdata;
  endtask

  task automatic wstb(input logic [15:0] w, output logic we, output logic [1:0] be,
                      output logic [15:0] wd, output logic [14:0] ma);
    @(negedge clk); host_wr_stb = 1; host_wdata = w;
    #1; we = mem_we; be = mem_be; wd = mem_wdata; ma = mem_addr;
    @(negedge clk); host_wr_stb = 0;
  endtask

  function automatic logic [15:0] exp_rd(input logic [1:0] c, input logic [15:0] a);
    logic [7:0] lo, hi;
    lo = fb({a[15:1], 1'b0}); hi = fb({a[15:1], 1'b1});
    if (!c[0]) return {8'h00, fb(a)};
    return c[1] ? {lo, hi} : {hi, lo};
  endfunction

  // cfg, start, len, strobes, end address
  localparam logic [57:0] VEC [6] = '{
    {2'b00, 16'h0010, 16'd3, 8'd3, 16'h0013},
    {2'b01, 16'h0100, 16'd4, 8'd2, 16'h0104},
    {2'b11, 16'h2000, 16'd6, 8'd3, 16'h2006},
    {2'b01, 16'hFFFE, 16'd4, 8'd2, 16'h0002},
    {2'b01, 16'h0040, 16'd3, 8'd2, 16'h0044},
    {2'b10, 16'h0081, 16'd2, 8'd2, 16'h0083}
  };

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v, d;
    logic we;
    logic [1:0] be;
    logic [15:0] wd;
    logic [14:0] ma;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 host_rdata", host_rdata, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_addr", mem_addr, 0);
    rd(6, b); chk("R1 status", b, 0);
    rd16(1, v); chk("R1 address", v, 0);
    rd16(3, v); chk("R1 count", v, 0);
    rd(0, b); chk("R1 command", b, 0);
    rd(5, b); chk("R1 config", b, 0);

    // Vector table: host reads (R2 R3 R4 R8 R10)
    for (int i = 0; i < 6; i++) begin
      logic [1:0] c; logic [15:0] s, n, e, a; logic [7:0] k;
      {c, s, n, k, e} = VEC[i];
      prog(s, n, c);
      wr(6, 8'h40);
      wr(0, 8'h01);
      rd16(1, v); chk("R2 load start", v, s);
      rd16(3, v); chk("R2 load count", v, n);
      rd(0, b); chk("R10 command readback", b, 8'h01);
      a = s;
      for (int j = 0; j < int'(k); j++) begin
        rstb(d); chk("R8 read data", d, exp_rd(c, a));
        a = a + (c[0] ? 16'd2 : 16'd1);
      end
      rd(6, b); chk("R4 done flag", b, 8'h40);
      rd16(1, v); chk("R3 end address", v, e);
      rd16(3, v); chk("R3 count zero", v, 0);
      rstb(d);
      rd16(1, v); chk("R11 idle strobe", v, e);
    end

    // R5 write-one-to-clear
    wr(6, 8'h00); rd(6, b); chk("R5 zero write keeps", b, 8'h40);
    wr(6, 8'h40); rd(6, b); chk("R5 clear", b, 8'h00);

    // R9 word writes, plain then swapped
    prog(16'h0300, 16'd3, 2'b01);
    wr(0, 8'h02);
    rstb(d);
    rd16(1, v); chk("R11 wrong direction strobe", v, 16'h0300);
    wstb(16'hBEEF, we, be, wd, ma);
    chk("R9 we", we, 1); chk("R9 be word", be, 2'b11);
    chk("R9 wdata plain", wd, 16'hBEEF); chk("R9 mem_addr", ma, 15'h0180);
    wr(5, 8'h03);
    wstb(16'h1234, we, be, wd, ma);
    chk("R9 wdata swapped", wd, 16'h3412); chk("R9 mem_addr next", ma, 15'h0181);
    rd(6, b); chk("R3 odd count word done", b, 8'h40);
    rd16(1, v); chk("R3 odd count end", v, 16'h0304);
    wstb(16'h5555, we, be, wd, ma); chk("R11 idle write", we, 0);

    // R9 byte write at odd address
    prog(16'h0301, 16'd1, 2'b00);
    wr(0, 8'h02);
    wstb(16'h00A7, we, be, wd, ma);
    chk("R9 byte be odd", be, 2'b10); chk("R9 byte wdata", wd, 16'hA7A7);

    // R6 abort
    wr(6, 8'h40);
    prog(16'h0500, 16'd10, 2'b00);
    wr(0, 8'h01);
    repeat (3) rstb(d);
    wr(0, 8'h04);
    rd16(1, v); chk("R6 address kept", v, 16'h0503);
    rd(6, b); chk("R6 no done", b, 0);
    rstb(d);
    rd16(1, v); chk("R6 strobe after abort", v, 16'h0503);
    rd(0, b); chk("R10 abort readback", b, 8'h04);

    // R7 ignored commands
    prog(16'h0600, 16'd4, 2'b00);
    wr(0, 8'h01);
    rstb(d);
    wr(0, 8'h00); wr(0, 8'h03);
    rd(0, b); chk("R7 command kept", b, 8'h01);
    rd16(1, v); chk("R7 address kept", v, 16'h0601);
    rd16(3, v); chk("R7 count kept", v, 16'd3);
    rstb(d);
    rd16(1, v); chk("R7 transfer continues", v, 16'h0602);

    // R4 zero-length command
    wr(0, 8'h04);
    wr(6, 8'h40);
    prog(16'h0700, 16'd0, 2'b00);
    wr(0, 8'h01);
    rd(6, b); chk("R4 zero length done", b, 8'h40);
    rd16(1, v); chk("R4 zero length address", v, 16'h0700);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule